// File: doc/BRIEF.md
# MII link and duplex resolver

This block runs one link check each time it is triggered. It reads a PHY's basic status word and then its link-partner ability word through a simple MDIO master request port. From these words it decides whether a PHY is present and whether the link is up. It then works out the duplex and speed that both ends support and updates two MAC mode bits: full duplex and transmit threshold.

When the check changes either mode bit, the block sends a one-cycle restart request to the transmit and receive engines. Each check ends with a two-bit result code, which stays valid until the next check is accepted. The MDIO serial timing sits behind the request port, and the MAC datapath is outside this block.

A status read is treated as a request that stays raised until the port acknowledges it. The acknowledge cycle also carries the read data.

Top module: `mii_link_resolver`

## Requirements
- R1: After reset, `full_duplex` is 0, `tx_threshold` is 1, and `result_valid`, `restart_pulse`, `busy` and `mdio_req` are all 0.
- R2: A check is accepted on `check_req` while idle, and `phy_addr` is captured at that moment. It first reads register 1 (status), then register 5 (partner ability), both at the captured address. Each request holds `mdio_req`, `mdio_reg` and `mdio_phy` steady until the cycle in which `mdio_ack` is high.
- R3: If the status word is 0xFFFF, the check ends after those two reads with code 2'b10 (minus two, PHY missing). The mode bits stay unchanged and no restart is sent.
- R4: If status bit 2 (link) is 0, register 1 is read once more. If bit 2 is still 0, the check ends after three reads with code 2'b11 (minus one, no link), with the mode bits unchanged and no restart.
- R5: If that second status read shows bit 2 set, resolution goes ahead using the partner word that was already read.
- R6: The negotiated set is the partner word ANDed with `local_adv`. `tx_threshold` becomes 0 when any of negotiated bits 9, 8 or 7 is set, and becomes 1 otherwise.
- R7: `full_duplex` becomes 1 in any of three cases: `duplex_lock` is set, negotiated bit 8 is set, or negotiated bits 8:6 equal 3'b001. In every other case it becomes 0.
- R8: When a resolved check changes either mode bit, `restart_pulse` is high for exactly one cycle, in the same cycle that `result_valid` rises, and the code is 2'b01. If neither bit changes, the code is 2'b00 and no pulse is sent.
- R9: `result_valid` falls when a check is accepted and stays high from the end of the check until the next accepted trigger. `check_req` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_req | input | 1 | Starts a check when idle |
| phy_addr | input | 5 | PHY address, captured at trigger |
| local_adv | input | 16 | Local advertisement word |
| duplex_lock | input | 1 | Forces full duplex |
| mdio_req | output | 1 | Read request to the MDIO master |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_ack | input | 1 | Read done; data valid this cycle |
| mdio_rdata | input | 16 | Read data |
| busy | output | 1 | A check is in progress |
| result_valid | output | 1 | Result code is valid |
| result_code | output | 2 | 00 ok, 01 changed, 11 no link, 10 missing |
| full_duplex | output | 1 | MAC full-duplex mode bit |
| tx_threshold | output | 1 | MAC transmit-threshold mode bit |
| restart_pulse | output | 1 | One-cycle restart of the transmit and receive engines |

## Verification
The status and partner words are chosen to split apart each outcome of the check: a missing PHY, a link that stays down, a link that comes back on the re-read, and a link that is up at once. The read count and the register order tell these paths apart.

Among the link-up cases, the partner and advertisement pairs cover several abilities: 100 Mb/s full, 10 Mb/s full only, 10 Mb/s half, 100 Mb/s half only, and the bit-9 ability on its own, plus a case with the duplex lock set. These separate the threshold rule from the duplex rule, and show that only abilities both ends share count. Repeating an identical check shows the no-change path, with code 00 and no restart. A second trigger sent mid-check shows that triggers are ignored while busy.

// File: rtl/mii_res_pkg.sv
// Package: shared constants and state type for the link/duplex resolver.
// Assumes: standard MII management register numbering and bit positions.
package mii_res_pkg;

    localparam int          PHY_AW      = 5;
    localparam int          WORD_W      = 16;
    localparam logic [4:0]  REG_STATUS  = 5'd1;
    localparam logic [4:0]  REG_PARTNER = 5'd5;
    localparam int          LINK_BIT    = 2;

    localparam logic [1:0]  CODE_OK      = 2'b00;
    localparam logic [1:0]  CODE_CHANGED = 2'b01;
    localparam logic [1:0]  CODE_NOLINK  = 2'b11;
    localparam logic [1:0]  CODE_MISSING = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_PART,
        ST_EVAL,
        ST_RD_RECHK
    } res_state_t;

endpackage

// File: rtl/mii_res_decide.sv
// Module: mii_res_decide
// Combinational ability resolver. Takes the partner ability word and the
// local advertisement and produces the next full-duplex and tx-threshold
// values. Assumes the standard ability bit layout (bit 5 = 10 half,
// 6 = 10 full, 7 = 100 half, 8 = 100 full, 9 = 100 T4).
module mii_res_decide #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] partner_word,
    input  logic [WORD_W-1:0] adv_word,
    input  logic              lock_full,
    output logic              full_next,
    output logic              thr_next
);

    logic [WORD_W-1:0] common;
    logic              any_fast;
    logic              ten_full_only;

    // Purpose: form the shared ability set and derive both mode bits.
    always_comb begin
        common        = partner_word & adv_word;
        any_fast      = |common[9:7];
        ten_full_only = (common[8:6] == 3'b001);
        thr_next      = ~any_fast;
        full_next     = lock_full | common[8] | ten_full_only;
    end

endmodule

// File: rtl/mii_res_mode.sv
// Module: mii_res_mode
// Holds the MAC mode bits (full duplex, transmit threshold). On an update
// strobe it loads the resolved values and raises a one-cycle restart when
// either bit differs from the stored one. Assumes update strobes are never
// back to back.
module mii_res_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic full_next,
    input  logic thr_next,
    output logic full_q,
    output logic thr_q,
    output logic differs,
    output logic restart
);

    // Purpose: flag a difference between resolved and stored mode.
    always_comb begin
        differs = (full_next != full_q) || (thr_next != thr_q);
    end

    // Purpose: mode register and restart strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            thr_q   <= 1'b1;
            restart <= 1'b0;
        end else begin
            restart <= upd_en && differs;
            if (upd_en) begin
                full_q <= full_next;
                thr_q  <= thr_next;
            end
        end
    end

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);  // R8

    AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (full_q != $past(full_q)) || (thr_q != $past(thr_q)));  // R8

endmodule

// File: rtl/mii_res_ctrl.sv
// Module: mii_res_ctrl
// Sequencer for one link check: status read, partner read, evaluation,
// and an optional status re-read when the latched-low link bit is clear.
// Ends with a result code held until the next accepted trigger.
// Assumes the MDIO master keeps data valid in the cycle mdio_ack is high.
module mii_res_ctrl
    import mii_res_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_req,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_ack,
    input  logic [WORD_W-1:0] mdio_rdata,
    input  logic              mode_change,
    output logic              mdio_req,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [4:0]        mdio_reg,
    output logic [WORD_W-1:0] partner_q,
    output logic              upd_en,
    output logic              busy,
    output logic              result_valid,
    output logic [1:0]        result_code
);

    localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

    res_state_t        state;
    logic [WORD_W-1:0] stat_q;
    logic [ADDR_W-1:0] phy_q;
    logic              rechk_done;
    logic              stat_missing;
    logic              link_up;

    // Purpose: classify the latest status word.
    always_comb begin
        stat_missing = (stat_q == ALL_ONES);
        link_up      = stat_q[LINK_BIT];
    end

    // Purpose: drive the MDIO request port and the update strobe from state.
    always_comb begin
        mdio_req = (state == ST_RD_STAT) || (state == ST_RD_PART) ||
                   (state == ST_RD_RECHK);
        mdio_reg = (state == ST_RD_PART) ? REG_PARTNER : REG_STATUS;
        mdio_phy = phy_q;
        busy     = (state != ST_IDLE);
        upd_en   = (state == ST_EVAL) && !stat_missing && link_up;
    end

    // Purpose: check sequencer with captured words and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            stat_q       <= '0;
            partner_q    <= '0;
            phy_q        <= '0;
            rechk_done   <= 1'b0;
            result_valid <= 1'b0;
            result_code  <= CODE_OK;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (check_req) begin
                        phy_q        <= phy_addr;
                        rechk_done   <= 1'b0;
                        result_valid <= 1'b0;
                        state        <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (mdio_ack) begin
                        stat_q <= mdio_rdata;
                        state  <= ST_RD_PART;
                    end
                end
                ST_RD_PART: begin
                    if (mdio_ack) begin
                        partner_q <= mdio_rdata;
                        state     <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (stat_missing) begin
                        result_code  <= CODE_MISSING;
                        result_valid <= 1'b1;
                        state        <= ST_IDLE;
                    end else if (!link_up) begin
                        if (rechk_done) begin
                            result_code  <= CODE_NOLINK;
                            result_valid <= 1'b1;
                            state        <= ST_IDLE;
                        end else begin
                            state <= ST_RD_RECHK;
                        end
                    end else begin
                        result_code  <= mode_change ? CODE_CHANGED : CODE_OK;
                        result_valid <= 1'b1;
                        state        <= ST_IDLE;
                    end
                end
                ST_RD_RECHK: begin
                    if (mdio_ack) begin
                        stat_q     <= mdio_rdata;
                        rechk_done <= 1'b1;
                        state      <= ST_EVAL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> mdio_req && $stable(mdio_reg) && $stable(mdio_phy));  // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !mdio_req && !busy);  // R9

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && check_req) |=> !result_valid || $past(state) == ST_EVAL);  // R9

endmodule

// File: rtl/mii_link_resolver.sv
// Module: mii_link_resolver (top)
// Periodic MII link check: reads PHY status and partner ability over an
// MDIO request port, resolves duplex and speed, updates the MAC mode bits
// and pulses a restart on change. Assumes one outstanding MDIO read at a time.
module mii_link_resolver
    import mii_res_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_req,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [WORD_W-1:0] local_adv,
    input  logic              duplex_lock,
    output logic              mdio_req,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [4:0]        mdio_reg,
    input  logic              mdio_ack,
    input  logic [WORD_W-1:0] mdio_rdata,
    output logic              busy,
    output logic              result_valid,
    output logic [1:0]        result_code,
    output logic              full_duplex,
    output logic              tx_threshold,
    output logic              restart_pulse
);

    logic [WORD_W-1:0] partner_w;
    logic              upd_w;
    logic              differs_w;
    logic              full_nx;
    logic              thr_nx;

    mii_res_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .check_req    (check_req),
        .phy_addr     (phy_addr),
        .mdio_ack     (mdio_ack),
        .mdio_rdata   (mdio_rdata),
        .mode_change  (differs_w),
        .mdio_req     (mdio_req),
        .mdio_phy     (mdio_phy),
        .mdio_reg     (mdio_reg),
        .partner_q    (partner_w),
        .upd_en       (upd_w),
        .busy         (busy),
        .result_valid (result_valid),
        .result_code  (result_code)
    );

    mii_res_decide #(.WORD_W(WORD_W)) u_decide (
        .partner_word (partner_w),
        .adv_word     (local_adv),
        .lock_full    (duplex_lock),
        .full_next    (full_nx),
        .thr_next     (thr_nx)
    );

    mii_res_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_w),
        .full_next (full_nx),
        .thr_next  (thr_nx),
        .full_q    (full_duplex),
        .thr_q     (tx_threshold),
        .differs   (differs_w),
        .restart   (restart_pulse)
    );

    AST_FAULT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(result_valid) && result_code[1]) |-> $stable(full_duplex) && $stable(tx_threshold) && !restart_pulse);  // R3

    AST_RESTART_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> $rose(result_valid) && result_code == CODE_CHANGED);  // R8

endmodule

// File: tb/sim_mii_link_resolver.sv
`timescale 1ns/1ps
module sim_mii_link_resolver;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        check_req;
    logic [4:0]  phy_addr;
    logic [15:0] local_adv;
    logic        duplex_lock;
    logic        mdio_req;
    logic [4:0]  mdio_phy;
    logic [4:0]  mdio_reg;
    logic        mdio_ack;
    logic [15:0] mdio_rdata;
    logic        busy;
    logic        result_valid;
    logic [1:0]  result_code;
    logic        full_duplex;
    logic        tx_threshold;
    logic        restart_pulse;

    int vectors = 0;
    int miscompares = 0;

    // responder stimulus and log
    logic [15:0] stat1_v, stat2_v, lpa_v;
    int          n_reads;
    int          n_stat;
    logic [4:0]  reg_log [0:7];
    logic [4:0]  phy_log [0:7];

    // bench model of the mode bits
    logic m_full, m_thr;
    logic got_restart;

    always #2.5 clk = ~clk;

    mii_link_resolver u0 (
        .clk(clk), .rst_n(rst_n), .check_req(check_req), .phy_addr(phy_addr),
        .local_adv(local_adv), .duplex_lock(duplex_lock), .mdio_req(mdio_req),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_ack(mdio_ack),
        .mdio_rdata(mdio_rdata), .busy(busy), .result_valid(result_valid),
        .result_code(result_code), .full_duplex(full_duplex),
        .tx_threshold(tx_threshold), .restart_pulse(restart_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // MDIO responder: two-cycle latency, logs each read
    initial begin
        mdio_ack = 1'b0;
        mdio_rdata = '0;
        forever begin
            @(negedge clk);
            mdio_ack = 1'b0;
            if (mdio_req && rst_n) begin
                repeat (2) @(negedge clk);
                if (n_reads < 8) begin
                    reg_log[n_reads] = mdio_reg;
                    phy_log[n_reads] = mdio_phy;
                end
                n_reads++;
                if (mdio_reg == 5'd1) begin
                    mdio_rdata = (n_stat == 0) ? stat1_v : stat2_v;
                    n_stat++;
                end else begin
                    mdio_rdata = lpa_v;
                end
                mdio_ack = 1'b1;
            end
        end
    end

    task automatic run_check(input logic [15:0] s1, input logic [15:0] s2,
                             input logic [15:0] lp, input logic [15:0] ad,
                             input logic lk, input bit poke, input logic [4:0] pa);
        int cnt;
        stat1_v = s1; stat2_v = s2; lpa_v = lp;
        n_reads = 0; n_stat = 0;
        local_adv = ad; duplex_lock = lk; phy_addr = pa;
        @(negedge clk); check_req = 1'b1;
        @(negedge clk); check_req = 1'b0; phy_addr = ~pa;
        chk("R9 valid cleared on accept", {31'd0, result_valid}, 32'd0);
        if (poke) begin
            repeat (2) @(negedge clk);
            check_req = 1'b1;
            @(negedge clk); check_req = 1'b0;
        end
        cnt = 0;
        while (!result_valid && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        if (!result_valid) begin
            miscompares++;
            $display("FAIL R9 check never finished actual=0 expected=1");
        end
        got_restart = restart_pulse;
        chk("R2 phy address latched", {27'd0, phy_log[0]}, {27'd0, pa});
        @(negedge clk);
        chk("R8 restart one cycle", {31'd0, restart_pulse}, 32'd0);
    endtask

    task automatic expect_resolved(input logic [15:0] lp, input logic [15:0] ad, input logic lk);
        logic [15:0] neg;
        logic ef, et, chg;
        neg = lp & ad;
        et  = !(neg[9] | neg[8] | neg[7]);
        ef  = lk | neg[8] | (neg[8:6] == 3'b001);
        chg = (ef != m_full) || (et != m_thr);
        chk("R6 tx_threshold", {31'd0, tx_threshold}, {31'd0, et});
        chk("R7 full_duplex", {31'd0, full_duplex}, {31'd0, ef});
        chk("R8 result code", {30'd0, result_code}, chg ? 32'd1 : 32'd0);
        chk("R8 restart on change", {31'd0, got_restart}, {31'd0, chg});
        m_full = ef; m_thr = et;
    endtask

    task automatic t_reset;
        chk("R1 full_duplex", {31'd0, full_duplex}, 32'd0);
        chk("R1 tx_threshold", {31'd0, tx_threshold}, 32'd1);
        chk("R1 result_valid", {31'd0, result_valid}, 32'd0);
        chk("R1 restart", {31'd0, restart_pulse}, 32'd0);
        chk("R1 busy/req", {30'd0, busy, mdio_req}, 32'd0);
    endtask

    task automatic t_missing(input bit poke);
        run_check(16'hFFFF, 16'hFFFF, 16'h01E1, 16'h01E1, 1'b0, poke, 5'h0A);
        chk("R3 code missing", {30'd0, result_code}, 32'd2);
        chk("R3 two reads", n_reads, 2);
        chk("R2 first reg status", {27'd0, reg_log[0]}, 32'd1);
        chk("R2 second reg partner", {27'd0, reg_log[1]}, 32'd5);
        chk("R3 no restart", {31'd0, got_restart}, 32'd0);
        chk("R3 mode kept", {30'd0, full_duplex, tx_threshold}, {30'd0, m_full, m_thr});
    endtask

    task automatic t_nolink;
        run_check(16'h7809, 16'h7809, 16'h01E1, 16'h01E1, 1'b0, 1'b0, 5'h03);
        chk("R4 code no link", {30'd0, result_code}, 32'd3);
        chk("R4 three reads", n_reads, 3);
        chk("R4 re-read status", {27'd0, reg_log[2]}, 32'd1);
        chk("R4 no restart", {31'd0, got_restart}, 32'd0);
        chk("R4 mode kept", {30'd0, full_duplex, tx_threshold}, {30'd0, m_full, m_thr});
    endtask

    task automatic t_up(input logic [15:0] lp, input logic [15:0] ad, input logic lk);
        run_check(16'h782D, 16'h782D, lp, ad, lk, 1'b0, 5'h11);
        chk("R2 two reads when link up", n_reads, 2);
        expect_resolved(lp, ad, lk);
    endtask

    task automatic t_recover;
        run_check(16'h7809, 16'h782D, 16'h0061, 16'h01E1, 1'b0, 1'b0, 5'h1F);
        chk("R5 three reads", n_reads, 3);
        expect_resolved(16'h0061, 16'h01E1, 1'b0);
    endtask

    task automatic t_hold;
        repeat (20) @(negedge clk);
        chk("R9 result held", {29'd0, result_valid, result_code}, {29'd0, 1'b1, 2'b00});
        chk("R9 no request while idle", {31'd0, mdio_req}, 32'd0);
    endtask

    // global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; check_req = 1'b0; phy_addr = '0; local_adv = '0; duplex_lock = 1'b0;
        stat1_v = '0; stat2_v = '0; lpa_v = '0; n_reads = 0; n_stat = 0;
        m_full = 1'b0; m_thr = 1'b1; got_restart = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();                                   // R1
        t_missing(1'b0);                             // R2, R3
        t_nolink();                                  // R4
        t_up(16'h01E1, 16'h01E1, 1'b0);              // 100 full: R6 R7 R8
        t_up(16'h01E1, 16'h01E1, 1'b0);              // no change: R8
        t_hold();                                    // R9
        t_recover();                                 // R5, 10 full only
        t_up(16'h0021, 16'h01E1, 1'b0);              // 10 half: R7
        t_up(16'h0021, 16'h01E1, 1'b1);              // lock: R7
        t_up(16'h01E1, 16'h00A1, 1'b0);              // 100 half via common set: R6 R7
        t_up(16'h0201, 16'h0201, 1'b0);              // bit 9 alone: R6
        t_missing(1'b1);                             // trigger while busy: R9
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule